// File: doc/BRIEF.md
# Prescaled 64-bit Alarm Timer

The block is a free-standing 64-bit up-counter with one alarm comparator, reached over a small 32-bit register bus. A programmable divider turns the bus clock into count ticks. Software sees the count only through a pair of snapshot registers. These are refreshed on request and land one divider period later, with no completion flag. A new count is staged as two 32-bit halves and committed with a separate strobe.

The alarm is a 64-bit value held in two halves, armed by its own config bit. When the armed compare goes true, a sticky status bit is raised. Software must clear it explicitly. The interrupt line is the status bit gated by an enable bit. It is driven either as a level or as a one-cycle pulse.

Register word offsets: 0 config, 1 snapshot low, 2 snapshot high, 3 snapshot request, 4 staged load low, 5 staged load high, 6 load commit, 7 alarm low, 8 alarm high, 9 interrupt enable, 10 interrupt status, 11 interrupt clear. Config fields are:
- bit 0: run
- bit 1: count-up
- bit 2: alarm arm
- bit 3: level mode (1 = level, 0 = pulse)
- bits 31:16: divider

Top module: `alarm_timer64`

## Requirements
- R1: After reset, config reads 0, both alarm halves read 0xFFFFFFFF, both snapshot halves read 0, status (offset 10, bit 0) reads 0 and irq_o is low.
- R2: The count advances by one per divider period (config bits 31:16, values of 2 or more) only while config bit 0 and bit 1 are both set; with either clear it holds.
- R3: Writing 1 to bit 0 of offset 3 copies the live count into offsets 1 (low) and 2 (high) within one divider period; without such a write, those registers keep their value while the count runs.
- R4: Writing offsets 4 and 5 and then 1 to bit 0 of offset 6 makes the count equal the staged 64-bit value.
- R5: With config bit 2 set, status bit 0 sets once the count is greater than or equal to the alarm (offset 7 low, offset 8 high). It sets on the compare becoming true, and not earlier.
- R6: With config bit 2 clear, status never sets, whatever the count and alarm.
- R7: Status stays set until 1 is written to bit 0 of offset 11. Writing 0 there has no effect. A compare that simply stays true does not set it again.
- R8: In level mode (config bit 3 = 1), irq_o equals status AND the enable bit (offset 9, bit 0). Status stays readable while masked.
- R9: In pulse mode (config bit 3 = 0), irq_o is high for exactly one cycle when status AND enable becomes true.
- R10: Arming an alarm that is already below the count sets status within a few cycles, not after a wraparound.
- R11: A read returns data on rdata_o one cycle after rd_en_i. Offsets 12 to 15 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus and counter clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe, data valid next cycle |
| addr_i | input | 4 | Register word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Alarm interrupt, level or pulse |

## Verification
The hardest situation to reach is a snapshot taken from a count that is carrying from the low half into the high half. Only then would a torn read show up. The stimulus loads random values, some placed just below a 32-bit boundary, and runs for a random number of cycles at a random divider. It then reads back through the polling sequence and bounds the result against the elapsed cycles. The other hard case is an alarm whose compare was already true when it was armed or cleared. It is reached by moving the alarm below a stopped count and toggling the arm bit.

// File: rtl/alarm_timer64_pkg.sv
package alarm_timer64_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DIV_W  = 16;
  localparam int unsigned CNT_W  = 2 * REG_W;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG    = 4'd0,
    A_CNT_LO = 4'd1,
    A_CNT_HI = 4'd2,
    A_SNAP   = 4'd3,
    A_LD_LO  = 4'd4,
    A_LD_HI  = 4'd5,
    A_LD     = 4'd6,
    A_ALM_LO = 4'd7,
    A_ALM_HI = 4'd8,
    A_IEN    = 4'd9,
    A_IST    = 4'd10,
    A_ICLR   = 4'd11
  } reg_addr_e;

  typedef struct packed {
    logic [DIV_W-1:0]        div;
    logic [REG_W-DIV_W-5:0]  rsvd;
    logic                    level;
    logic                    arm;
    logic                    up;
    logic                    en;
  } cfg_t;
endpackage

// File: rtl/alarm_timer64_tick.sv
module alarm_timer64_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             last;

  // divider values 0 and 1 both give a tick every cycle
  assign last   = ({1'b0, cnt_q} + (DIV_W+1)'(1)) >= {1'b0, div_i};
  assign tick_o = last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (last) cnt_q <= '0;
    else           cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/alarm_timer64_core.sv
module alarm_timer64_core #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             snap_req_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] snap_o
);
  logic [CNT_W-1:0] count_q, snap_q;
  logic             pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               count_q <= '0;
    else if (load_i)           count_q <= load_val_i;
    else if (tick_i && run_i)  count_q <= count_q + CNT_W'(1);
  end

  // snapshot lands on the next prescaler tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      pend_q <= 1'b0;
    end else if (tick_i && (pend_q || snap_req_i)) begin
      snap_q <= count_q;
      pend_q <= 1'b0;
    end else if (snap_req_i) begin
      pend_q <= 1'b1;
    end
  end

  assign count_o = count_q;
  assign snap_o  = snap_q;
endmodule

// File: rtl/alarm_timer64_irq.sv
module alarm_timer64_irq #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] alarm_i,
  input  logic             arm_i,
  input  logic             ien_i,
  input  logic             level_i,
  input  logic             clr_i,
  output logic             status_o,
  output logic             irq_o
);
  logic match, match_q, status_q, masked, masked_q;

  assign match  = arm_i && (count_i >= alarm_i);
  assign masked = status_q && ien_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q  <= 1'b0;
      status_q <= 1'b0;
      masked_q <= 1'b0;
    end else begin
      match_q  <= match;
      masked_q <= masked;
      // a new compare hit wins over a clear in the same cycle
      if (match && !match_q) status_q <= 1'b1;
      else if (clr_i)        status_q <= 1'b0;
    end
  end

  assign status_o = status_q;
  assign irq_o    = level_i ? masked : (masked && !masked_q);
endmodule

// File: rtl/alarm_timer64.sv
module alarm_timer64
  import alarm_timer64_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  cfg_t             cfg_q;
  logic [CNT_W-1:0] load_q, alarm_q, count_w, snap_w;
  logic             ien_q, status_w, tick_w, run_w;
  logic             snap_req, load_stb, clr_stb;
  logic [REG_W-1:0] rd_mux, rdata_q;

  assign snap_req = wr_en_i && (addr_i == A_SNAP) && wdata_i[0];
  assign load_stb = wr_en_i && (addr_i == A_LD)   && wdata_i[0];
  assign clr_stb  = wr_en_i && (addr_i == A_ICLR) && wdata_i[0];
  assign run_w    = cfg_q.en && cfg_q.up;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      load_q  <= '0;
      alarm_q <= '1;
      ien_q   <= 1'b0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_CFG:    cfg_q                  <= cfg_t'(wdata_i);
        A_LD_LO:  load_q[REG_W-1:0]      <= wdata_i;
        A_LD_HI:  load_q[CNT_W-1:REG_W]  <= wdata_i;
        A_ALM_LO: alarm_q[REG_W-1:0]     <= wdata_i;
        A_ALM_HI: alarm_q[CNT_W-1:REG_W] <= wdata_i;
        A_IEN:    ien_q                  <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      A_CFG:    rd_mux = cfg_q;
      A_CNT_LO: rd_mux = snap_w[REG_W-1:0];
      A_CNT_HI: rd_mux = snap_w[CNT_W-1:REG_W];
      A_LD_LO:  rd_mux = load_q[REG_W-1:0];
      A_LD_HI:  rd_mux = load_q[CNT_W-1:REG_W];
      A_ALM_LO: rd_mux = alarm_q[REG_W-1:0];
      A_ALM_HI: rd_mux = alarm_q[CNT_W-1:REG_W];
      A_IEN:    rd_mux = {{(REG_W-1){1'b0}}, ien_q};
      A_IST:    rd_mux = {{(REG_W-1){1'b0}}, status_w};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;

  alarm_timer64_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (cfg_q.div),
    .tick_o (tick_w)
  );

  alarm_timer64_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_w),
    .run_i      (run_w),
    .load_i     (load_stb),
    .load_val_i (load_q),
    .snap_req_i (snap_req),
    .count_o    (count_w),
    .snap_o     (snap_w)
  );

  alarm_timer64_irq #(.CNT_W(CNT_W)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .count_i  (count_w),
    .alarm_i  (alarm_q),
    .arm_i    (cfg_q.arm),
    .ien_i    (ien_q),
    .level_i  (cfg_q.level),
    .clr_i    (clr_stb),
    .status_o (status_w),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/alarm_timer64_chk.sv
module alarm_timer64_chk #(
  parameter int unsigned CNT_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_i,
  input logic             status_i,
  input logic             ien_i,
  input logic             level_i,
  input logic             arm_i,
  input logic             clr_i,
  input logic             run_i,
  input logic             tick_i,
  input logic             load_i,
  input logic [CNT_W-1:0] load_val_i,
  input logic [CNT_W-1:0] count_i
);
  // R8
  level_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i && status_i && ien_i |-> irq_i);
  // R8
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> status_i && ien_i);
  // R9
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i && !level_i |=> !irq_i || level_i);
  // R7
  status_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i && !clr_i |=> status_i);
  // R6
  disarmed_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i && !status_i |=> !status_i);
  // R4
  load_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_i == $past(load_val_i));
  // R2
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_i && tick_i) && !load_i |=> $stable(count_i));
endmodule

bind alarm_timer64 alarm_timer64_chk #(.CNT_W(alarm_timer64_pkg::CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_i      (irq_o),
  .status_i   (status_w),
  .ien_i      (ien_q),
  .level_i    (cfg_q.level),
  .arm_i      (cfg_q.arm),
  .clr_i      (clr_stb),
  .run_i      (run_w),
  .tick_i     (tick_w),
  .load_i     (load_stb),
  .load_val_i (load_q),
  .count_i    (count_w)
);

// File: tb/alarm_timer64_tb.sv
module alarm_timer64_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cur_div = 2;

  alarm_timer64 u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] cfg_word(int div, bit lvl, bit arm, bit up, bit en);
    return {div[15:0], 12'd0, lvl, arm, up, en};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic set_cfg(int div, bit lvl, bit arm, bit up, bit en);
    cur_div = div;
    wr(4'd0, cfg_word(div, lvl, arm, up, en));
  endtask

  // request snapshot, poll low half, then read a consistent pair
  task automatic get_count(output logic [63:0] v);
    logic [31:0] lo0, lo, hi;
    rd(4'd1, lo0);
    wr(4'd3, 32'd1);
    lo = lo0;
    for (int i = 0; i < cur_div && lo == lo0; i++) rd(4'd1, lo);
    do begin
      lo0 = lo;
      rd(4'd2, hi);
      rd(4'd1, lo);
    end while (lo != lo0);
    v = {hi, lo};
  endtask

  task automatic load(logic [63:0] v);
    wr(4'd4, v[31:0]);
    wr(4'd5, v[63:32]);
    wr(4'd6, 32'd1);
  endtask

  task automatic set_alarm(logic [63:0] v);
    wr(4'd7, v[31:0]);
    wr(4'd8, v[63:32]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    logic [63:0] v, got, base;
    int n, div, hits;
    void'($urandom(32'h5eed1234));

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(4'd0, d);  chk(d == 0, "R1 cfg", d, 0);
    rd(4'd7, d);  chk(d == 32'hFFFF_FFFF, "R1 alarm lo", d, 32'hFFFF_FFFF);
    rd(4'd8, d);  chk(d == 32'hFFFF_FFFF, "R1 alarm hi", d, 32'hFFFF_FFFF);
    rd(4'd1, d);  chk(d == 0, "R1 snap lo", d, 0);
    rd(4'd2, d);  chk(d == 0, "R1 snap hi", d, 0);
    rd(4'd10, d); chk(d == 0, "R1 status", d, 0);
    chk(irq_o == 0, "R1 irq", irq_o, 0);

    // R11 undefined offsets and read latency
    wr(4'd13, 32'hFFFF_FFFF);
    rd(4'd13, d); chk(d == 0, "R11 undefined read", d, 0);
    wr(4'd9, 32'd1);
    rd(4'd9, d);  chk(d == 1, "R11 ien readback", d, 1);
    wr(4'd9, 32'd0);

    // R4/R2/R3 random loads and runs, some near a 32-bit carry
    for (int it = 0; it < 10; it++) begin
      div = 2 + ($urandom % 8);
      v = {$urandom, $urandom};
      if (it % 2 == 0) v[31:0] = 32'hFFFF_FFF0 + ($urandom % 16);
      set_cfg(div, 0, 0, 1, 0);
      load(v);
      get_count(got);
      chk(got == v, "R4 load value", got, v);
      n = 20 + ($urandom % 60);
      set_cfg(div, 0, 0, 1, 1);
      repeat (n) @(negedge clk_i);
      set_cfg(div, 0, 0, 1, 0);
      get_count(got);
      base = got - v;
      chk(base >= 64'(n / div - 1) && base <= 64'((n + 2) / div + 1),
          "R2 ticks per divider", base, 64'(n / div));
    end

    // R2 hold with only one of run/count-up set
    set_cfg(3, 0, 0, 1, 0);
    load(64'h0000_0001_0000_0000);
    set_cfg(3, 0, 0, 0, 1);
    repeat (30) @(negedge clk_i);
    get_count(got);
    chk(got == 64'h0000_0001_0000_0000, "R2 hold up clear", got, 64'h0000_0001_0000_0000);
    set_cfg(3, 0, 0, 1, 0);
    repeat (30) @(negedge clk_i);
    get_count(got);
    chk(got == 64'h0000_0001_0000_0000, "R2 hold run clear", got, 64'h0000_0001_0000_0000);

    // R3 snapshot holds without a request
    set_cfg(2, 0, 0, 1, 1);
    get_count(got);
    repeat (40) @(negedge clk_i);
    rd(4'd1, d);
    chk(d == got[31:0], "R3 snapshot stable", d, got[31:0]);
    get_count(v);
    chk(v > got, "R3 snapshot refresh", v, got);

    // R5 alarm ahead of a running count
    set_cfg(2, 1, 0, 1, 0);
    load(64'd1000);
    set_alarm(64'd1006);
    wr(4'd11, 32'd1);
    wr(4'd9, 32'd1);
    set_cfg(2, 1, 1, 1, 1);
    rd(4'd10, d); chk(d == 0, "R5 not early", d, 0);
    hits = 0;
    for (int i = 0; i < 60 && hits == 0; i++) begin
      rd(4'd10, d);
      if (d[0]) hits = 1;
    end
    chk(hits == 1, "R5 fires", hits, 1);
    set_cfg(2, 1, 1, 1, 0);
    get_count(got);
    chk(got >= 64'd1006 && got <= 64'd1012, "R5 count at fire", got, 64'd1006);
    chk(irq_o == 1, "R8 level irq", irq_o, 1);

    // R7 clear semantics
    wr(4'd11, 32'd0);
    rd(4'd10, d); chk(d == 1, "R7 zero write ignored", d, 1);
    wr(4'd11, 32'd1);
    rd(4'd10, d); chk(d == 0, "R7 cleared", d, 0);
    chk(irq_o == 0, "R7 irq dropped", irq_o, 0);
    repeat (10) @(negedge clk_i);
    rd(4'd10, d); chk(d == 0, "R7 no refire on held compare", d, 0);

    // R6 disarmed alarm below count
    set_cfg(2, 1, 0, 0, 0);
    set_alarm(64'd500);
    repeat (20) @(negedge clk_i);
    rd(4'd10, d); chk(d == 0, "R6 disarmed", d, 0);

    // R10 arming a past alarm
    set_cfg(2, 1, 1, 0, 0);
    repeat (4) @(negedge clk_i);
    rd(4'd10, d); chk(d == 1, "R10 past alarm", d, 1);

    // R8 masked status still visible
    wr(4'd9, 32'd0);
    wr(4'd11, 32'd1);
    set_cfg(2, 1, 0, 0, 0);
    set_cfg(2, 1, 1, 0, 0);
    repeat (3) @(negedge clk_i);
    rd(4'd10, d);
    chk(d == 1, "R8 masked status", d, 1);
    chk(irq_o == 0, "R8 masked irq", irq_o, 0);
    wr(4'd9, 32'd1);
    hits = 0;
    repeat (10) begin
      @(negedge clk_i);
      if (irq_o) hits++;
    end
    chk(hits == 10, "R8 level held", hits, 10);

    // R9 pulse mode
    wr(4'd11, 32'd1);
    set_cfg(2, 0, 0, 0, 0);
    set_cfg(2, 0, 1, 0, 0);
    hits = 0;
    repeat (20) begin
      @(negedge clk_i);
      if (irq_o) hits++;
    end
    chk(hits == 1, "R9 single pulse", hits, 1);
    rd(4'd10, d2); chk(d2 == 1, "R9 status kept", d2, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule